// File: doc/BRIEF.md
# Fault Interrupt Pulse Generator

This block watches a bank of eight fault flags (one over-temperature flag and one open-load flag per output channel) and turns the appearance of any new fault into a single interrupt pulse of fixed length. The pulse drives an active-low interrupt line that several devices share through an open-drain connection. In RTL it appears as a drive-low enable: when the enable is 1 the pad pulls the line low, and when it is 0 the pad is released and an external pull-up holds the line high.

A trigger is any flag bit that is 1 in the current cycle and was 0 in the previous cycle. This includes a second fault that appears while another flag is already set. When a trigger arrives and no pulse is running, the block asserts the enable for exactly `PULSE_CYCLES` system clock cycles. The default is 2500 cycles, which is 10 µs at 250 MHz and sits inside the 3 to 25 µs window. Triggers that arrive during a pulse are discarded and are not queued. The host still learns about those faults by reading the flags through the diagnostic shift path, which lies outside this block.

Two resets act on the block. The system reset returns it to idle. The device's own active-low reset releases the line at once, aborts any pulse and blocks new triggers for as long as it is held.

Top module: `faultIrqOneShot`

## Requirements
- R1: While `sysRstN` is low and after it rises with all flags at 0, `intDriveLow` is 0.
- R2: A 0-to-1 change on any one of the `N_FLAGS` bits of `faultFlags`, seen while idle and with `devRstN` high, starts a pulse. `intDriveLow` becomes 1 in the cycle after the clock edge that samples the change.
- R3: A pulse keeps `intDriveLow` at 1 for exactly `PULSE_CYCLES` consecutive cycles and then returns it to 0.
- R4: New flag bits that rise while a pulse is active neither lengthen the pulse nor cause a second pulse after it ends.
- R5: Flags that stay at 1 produce no further pulse once the pulse has ended. Only a 0-to-1 change triggers.
- R6: A bit that rises while other bits are already 1 starts a new pulse, provided no pulse is running.
- R7: While `devRstN` is 0, `intDriveLow` is 0 in the same cycle, any running pulse is abandoned, and flag changes seen during that time start no pulse, even after `devRstN` returns high.
- R8: A 1-to-0 change on a flag bit starts no pulse.
- R9: A trigger sampled on the first idle clock edge after a pulse ends is accepted and starts a full pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low system reset |
| devRstN | input | 1 | Synchronous active-low device reset. Releases the line and suppresses triggers |
| faultFlags | input | N_FLAGS | Fault flags: bits 0..3 are over-temperature, bits 4..7 are open-load |
| intDriveLow | output | 1 | 1 pulls the shared interrupt line low. 0 releases it |

## Verification
The bench targets the pulse boundaries. It measures the exact width for every flag position, which catches an off-by-one counter that would give a pulse one cycle short or long. It injects a new fault in the middle of a pulse: a retriggerable design would stretch the pulse or fire again. It holds flags steady across the end of a pulse: a level-sensitive design would pulse again. It places a trigger on the first idle cycle, which a lockout that lasts too long would swallow. It drops the device reset mid-pulse and raises flags while that reset is held: a design that only gated the output would resume the pulse, and a design that dropped the flag history would fire a stale pulse when the reset is released.

// File: rtl/irqPkg.sv
package irqPkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PULSE = 1'b1
  } irqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // load the pulse length
    logic step;   // count one pulse cycle down
    logic clear;  // empty the counter
  } irqStrobes_t;

endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int N_FLAGS      = 8,
  parameter int PULSE_CYCLES = 2500
) (
  input  logic               clk,
  input  logic               sysRstN,
  input  logic [N_FLAGS-1:0] faultFlags,
  input  irqStrobes_t        strobes,
  output logic               trig,
  output logic               cntLast
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES);

  logic [N_FLAGS-1:0] prevFlags;
  logic [N_FLAGS-1:0] newBits;
  logic [CNT_W-1:0]   remain;

  // The flag history keeps tracking during device reset, so that flags
  // raised then are never seen as new afterwards.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) prevFlags <= '0;
    else          prevFlags <= faultFlags;
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_edge
    assign newBits[i] = faultFlags[i] & ~prevFlags[i];
  end

  assign trig = |newBits;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)           remain <= '0;
    else if (strobes.clear) remain <= '0;
    else if (strobes.load)  remain <= LOAD_VAL;
    else if (strobes.step)  remain <= remain - 1'b1;
  end

  assign cntLast = (remain == CNT_W'(1));

endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        devRstN,
  input  logic        trig,
  input  logic        cntLast,
  output irqStrobes_t strobes,
  output logic        busy
);

  irqState_t state, nextState;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) state <= ST_IDLE;
    else          state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (devRstN && trig) begin
          strobes.load = 1'b1;
          nextState    = ST_PULSE;
        end
      end
      ST_PULSE: begin
        // Triggers are not looked at here: that is the lockout.
        if (!devRstN || cntLast) begin
          strobes.clear = 1'b1;
          nextState     = ST_IDLE;
        end else begin
          strobes.step = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_PULSE);

endmodule

// File: rtl/faultIrqOneShot.sv
module faultIrqOneShot
  import irqPkg::*;
#(
  parameter int N_FLAGS      = 8,
  parameter int PULSE_CYCLES = 2500
) (
  input  logic               clk,
  input  logic               sysRstN,
  input  logic               devRstN,
  input  logic [N_FLAGS-1:0] faultFlags,
  output logic               intDriveLow
);

  irqStrobes_t strobes;
  logic        trig;
  logic        cntLast;
  logic        busy;

  irqDatapath #(
    .N_FLAGS     (N_FLAGS),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) uDp (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .faultFlags(faultFlags),
    .strobes   (strobes),
    .trig      (trig),
    .cntLast   (cntLast)
  );

  irqControl uCtl (
    .clk    (clk),
    .sysRstN(sysRstN),
    .devRstN(devRstN),
    .trig   (trig),
    .cntLast(cntLast),
    .strobes(strobes),
    .busy   (busy)
  );

  // Device reset releases the line in the same cycle.
  assign intDriveLow = busy & devRstN;

endmodule

// File: rtl/irqChecker.sv
module irqChecker #(
  parameter int N_FLAGS      = 8,
  parameter int PULSE_CYCLES = 2500
) (
  input logic               clk,
  input logic               sysRstN,
  input logic               devRstN,
  input logic [N_FLAGS-1:0] faultFlags,
  input logic               intDriveLow
);

  logic [N_FLAGS-1:0] seenFlags;
  int unsigned        lowRun;
  logic               anyNew;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      seenFlags <= '0;
      lowRun    <= 0;
    end else begin
      seenFlags <= faultFlags;
      if (intDriveLow) begin
        if (lowRun < PULSE_CYCLES + 1) lowRun <= lowRun + 1;
      end else begin
        lowRun <= 0;
      end
    end
  end

  assign anyNew = |(faultFlags & ~seenFlags);

  // R7: device reset keeps the line released
  a_r7_dev_reset_release: assert property (@(posedge clk) disable iff (!sysRstN)
    !devRstN |-> !intDriveLow);

  // R2 / R9: a new fault while idle starts a pulse
  a_r2_trigger_starts: assert property (@(posedge clk) disable iff (!sysRstN)
    (devRstN && !intDriveLow && anyNew) |=> (intDriveLow || !devRstN));

  // R5 / R8: a pulse begins only after a newly set flag
  a_r5_rise_needs_new: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(intDriveLow) |-> $past(anyNew && devRstN));

  // R3: the pulse never runs longer than its length
  a_r3_max_width: assert property (@(posedge clk) disable iff (!sysRstN)
    lowRun <= PULSE_CYCLES);

  // R3 / R4: a pulse that ends naturally has the exact length
  a_r3_exact_width: assert property (@(posedge clk) disable iff (!sysRstN)
    ($fell(intDriveLow) && devRstN) |-> (lowRun == PULSE_CYCLES));

  // R3: the pulse does not stop early while the device reset is high
  a_r3_no_early_end: assert property (@(posedge clk) disable iff (!sysRstN)
    (intDriveLow && lowRun + 1 < PULSE_CYCLES) |=> (intDriveLow || !devRstN));

endmodule

bind faultIrqOneShot irqChecker #(
  .N_FLAGS     (N_FLAGS),
  .PULSE_CYCLES(PULSE_CYCLES)
) uChk (
  .clk        (clk),
  .sysRstN    (sysRstN),
  .devRstN    (devRstN),
  .faultFlags (faultFlags),
  .intDriveLow(intDriveLow)
);

// File: tb/sim_faultIrqOneShot.sv
`timescale 1ns/1ps
module sim_faultIrqOneShot;

  localparam int NF  = 8;
  localparam int LEN = 2500;   // expected pulse length per R3

  logic          clk = 1'b0;
  logic          sysRstN = 1'b0;
  logic          devRstN = 1'b1;
  logic [NF-1:0] faultFlags = '0;
  logic          intDriveLow;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  faultIrqOneShot u0 (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .devRstN    (devRstN),
    .faultFlags (faultFlags),
    .intDriveLow(intDriveLow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts consecutive high samples from the next negedge on.
  // The caller has just changed the inputs on a negedge.
  task automatic measure(output int width);
    width = 0;
    for (int k = 0; k < LEN + 20; k++) begin
      @(negedge clk);
      if (intDriveLow) width++;
      else break;
    end
  endtask

  // Waits n cycles and counts how many of them drive the line low.
  task automatic quietFor(input int n, output int seen);
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (intDriveLow) seen++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(intDriveLow == 1'b0, "R1 during reset", intDriveLow, 0);
    sysRstN = 1'b1;
    repeat (3) @(negedge clk);
    check(intDriveLow == 1'b0, "R1 after reset", intDriveLow, 0);
  endtask

  task automatic t_eachBit();
    int w;
    int seen;
    for (int b = 0; b < NF; b++) begin
      faultFlags = NF'(1) << b;
      measure(w);
      check(w == LEN, $sformatf("R2/R3 width bit %0d", b), w, LEN);
      faultFlags = '0;   // falling edge
      quietFor(4, seen);
      check(seen == 0, $sformatf("R8 fall bit %0d", b), seen, 0);
    end
  endtask

  task automatic t_lockout();
    int w;
    int seen;
    faultFlags = 8'h01;
    w = 0;
    for (int k = 0; k < LEN + 20; k++) begin
      @(negedge clk);
      if (!intDriveLow) break;
      w++;
      if (k == 3)       faultFlags = 8'h21;   // new bit mid pulse
      if (k == LEN - 1) faultFlags = 8'h23;   // new bit in the last pulse cycle
    end
    check(w == LEN, "R4 width with mid-pulse faults", w, LEN);
    quietFor(20, seen);
    check(seen == 0, "R4/R5 no pulse from held flags", seen, 0);
  endtask

  task automatic t_addBit();
    int w;
    faultFlags = 8'h27;   // bit 2 newly set, others held
    measure(w);
    check(w == LEN, "R6 added bit pulses", w, LEN);
    faultFlags = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_backToBack();
    int w;
    faultFlags = 8'h02;
    measure(w);   // returns on the first idle sample
    check(w == LEN, "R9 first pulse", w, LEN);
    faultFlags = 8'h12;   // sampled on the first idle edge
    measure(w);
    check(w == LEN, "R9 immediate retrigger", w, LEN);
    faultFlags = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_devReset();
    int w;
    int seen;
    faultFlags = 8'h08;
    repeat (10) @(negedge clk);
    check(intDriveLow == 1'b1, "R7 pulse running", intDriveLow, 1);
    devRstN = 1'b0;
    #0.5;
    check(intDriveLow == 1'b0, "R7 release same cycle", intDriveLow, 0);
    @(negedge clk);
    faultFlags = 8'h48;   // new bit during device reset
    quietFor(6, seen);
    check(seen == 0, "R7 no pulse while held", seen, 0);
    devRstN = 1'b1;
    quietFor(LEN + 10, seen);
    check(seen == 0, "R7 aborted pulse not resumed", seen, 0);
    faultFlags = 8'hC8;
    measure(w);
    check(w == LEN, "R7 normal pulse afterwards", w, LEN);
    faultFlags = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_eachBit();
    t_lockout();
    t_addBit();
    t_backToBack();
    t_devReset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule